// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is a single-clock SPI master that moves one word per request with serial clock phase 0. A start request, taken while the engine is idle, latches the transmit word and the whole configuration. The configuration covers the word length, the clock prescale, the clock polarity, the chip-select setup and hold delays and the hold flag. The engine then pulls chip-select low and waits a programmable number of interface-clock cycles. Partway through that wait it checks an active-low slave-ready input. It then toggles the serial clock, shifting data out MSB first and capturing the serial input on the active edge. Chip-select stays low for a programmable tail before it is released. The received word is returned together with a one-cycle done pulse.

With the hold flag set, a request that is pending at the end of a word keeps chip-select low. The next word starts straight away, without the tail delay, so that several words share one chip-select frame.

Top module: `spim_engine`

## Requirements
- R1: While reset is high, and in the first cycle after it, the outputs are cs_n=1, sclk=0, mosi=0, done=0 and rx_data=0.
- R2: One serial-clock period is ps_cfg+1 interface-clock cycles for ps_cfg in 1..255, and exactly 2 cycles for ps_cfg=0. For an odd period the high phase lasts floor(period/2) cycles and the low phase lasts the remaining ceiling.
- R3: pol_cfg=0 makes sclk idle low and capture on the falling edge. pol_cfg=1 makes it idle high and capture on the rising edge. The serial input is taken from its value in the last cycle before the active edge. Received bits fill rx_data MSB first and are right-aligned, with the unused upper bits zero. While idle, sclk follows pol_cfg with one cycle of delay.
- R4: mosi presents the MSB of the word from the first cycle of chip-select low. Each later bit appears at the leading (non-active) sclk edge, half a period before its active edge. mosi returns to 0 when chip-select is released.
- R5: The first sclk transition comes c2t_cfg+2 cycles after the first cycle with cs_n=0 when hold is 0, and c2t_cfg+3 cycles after it when hold is 1.
- R6: ena_n is checked in the cycle c2t_cfg+1 after chip-select assertion. If it is high there, the engine holds the clock idle and re-checks every cycle. The remaining setup time then counts on from the cycle in which ena_n is found low.
- R7: After the last active edge, chip-select stays low for the remaining half period plus t2c_cfg+1 cycles. done is high for exactly the one cycle in which cs_n rises, and rx_data carries the new word in that cycle.
- R8: With hold latched as 1, a start that is high in the last cycle of a word keeps cs_n low. That cycle's configuration is latched, done pulses, and the next word begins its setup delay from the following cycle.
- R9: A len_cfg value below 2 is treated as 2, and a value above 16 is treated as 16.
- R10: While a transfer is busy, start and all configuration inputs are ignored, except for start at the chaining point of R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Transfer request |
| tx_data | input | 16 | Word to send, right-aligned |
| len_cfg | input | 5 | Bits per word (2..16) |
| ps_cfg | input | 8 | Clock prescale value |
| pol_cfg | input | 1 | Serial clock idle level |
| c2t_cfg | input | 8 | Chip-select to clock delay |
| t2c_cfg | input | 8 | Clock to chip-select delay |
| hold_cfg | input | 1 | Keep chip-select between words |
| ena_n | input | 1 | Active-low slave ready |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip-select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| rx_data | output | 16 | Last received word |
| done | output | 1 | One-cycle end-of-word pulse |

## Verification
The serial engine is driven with even, odd and minimum prescale values under both polarities, so that phase-length rounding and the choice of active edge each show up as distinct cycle offsets. Setup timing is tried with the hold flag clear and set and with the ready input held back for several cycles. These patterns separate the fixed setup offset, the one-cycle hold extension and the stall re-sampling. Chained words with different lengths and prescales check that chip-select stays low and that the new configuration is taken at the boundary. Clamped lengths, and a request held high through a whole unchained word with changed configuration pins, show that only the latched settings act.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LEAD  = 3'd2,
    ST_TRAIL = 3'd3,
    ST_TAIL  = 3'd4
  } spim_state_e;

  localparam int MIN_BITS = 2;
endpackage

// File: rtl/spim_counter.sv
module spim_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spim_timing.sv
module spim_timing #(
  parameter int PS_W = 8
) (
  input  logic [PS_W-1:0] ps,
  input  logic            pol,
  output logic [PS_W:0]   half_lead,
  output logic [PS_W:0]   half_idle
);
  logic [PS_W:0] period, hi_len, lo_len;

  always_comb begin
    if (ps == '0) period = (PS_W+1)'(2);
    else          period = {1'b0, ps} + (PS_W+1)'(1);
    hi_len = period >> 1;
    lo_len = period - hi_len;
    // leading phase is the non-idle level
    half_lead = pol ? lo_len : hi_len;
    half_idle = pol ? hi_len : lo_len;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int W_MAX = 16,
  parameter int LEN_W = $clog2(W_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic [W_MAX-1:0] tx,
  input  logic             adv,
  input  logic             capture,
  input  logic             miso,
  input  logic             release_line,
  output logic             mosi,
  output logic [W_MAX-1:0] rx
);
  logic [W_MAX-1:0] tx_sh, aligned;
  logic [LEN_W-1:0] pad;

  always_comb begin
    pad     = LEN_W'(W_MAX) - len;
    aligned = tx << pad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
      rx    <= '0;
      mosi  <= 1'b0;
    end else if (load) begin
      tx_sh <= aligned;
      rx    <= '0;
      mosi  <= aligned[W_MAX-1];
    end else begin
      if (adv) begin
        tx_sh <= tx_sh << 1;
        mosi  <= tx_sh[W_MAX-2];
      end
      if (capture) rx <= {rx[W_MAX-2:0], miso};
      if (release_line) mosi <= 1'b0;
    end
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int W_MAX = 16,
  parameter int PS_W  = 8,
  parameter int DLY_W = 8,
  parameter int LEN_W = $clog2(W_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [W_MAX-1:0] tx_data,
  input  logic [LEN_W-1:0] len_cfg,
  input  logic [PS_W-1:0]  ps_cfg,
  input  logic             pol_cfg,
  input  logic [DLY_W-1:0] c2t_cfg,
  input  logic [DLY_W-1:0] t2c_cfg,
  input  logic             hold_cfg,
  input  logic             ena_n,
  input  logic             miso,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  output logic [W_MAX-1:0] rx_data,
  output logic             done
);
  localparam int WIDE  = (PS_W > DLY_W) ? PS_W : DLY_W;
  localparam int CNT_W = WIDE + 2;

  spim_state_e      st, st_nx;
  logic [PS_W-1:0]  ps_q;
  logic             pol_q, hold_q;
  logic [DLY_W-1:0] c2t_q, t2c_q;
  logic [LEN_W-1:0] len_q, len_cl, bit_q;
  logic [CNT_W-1:0] cnt, setup_chk, setup_last, lead_last, idle_last, tail_last;
  logic [PS_W:0]    half_lead, half_idle;
  logic [W_MAX-1:0] rx_sh;
  logic             cnt_clr, cnt_inc, load, adv, capture, finish, chain, last_bit;

  // length clamp to the supported range
  always_comb begin
    if (len_cfg < LEN_W'(MIN_BITS))   len_cl = LEN_W'(MIN_BITS);
    else if (len_cfg > LEN_W'(W_MAX)) len_cl = LEN_W'(W_MAX);
    else                              len_cl = len_cfg;
  end

  spim_timing #(.PS_W(PS_W)) i_timing (
    .ps        (ps_q),
    .pol       (pol_q),
    .half_lead (half_lead),
    .half_idle (half_idle)
  );

  spim_counter #(.W(CNT_W)) i_counter (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .inc (cnt_inc),
    .cnt (cnt)
  );

  spim_shifter #(.W_MAX(W_MAX), .LEN_W(LEN_W)) i_shifter (
    .clk          (clk),
    .rst          (rst),
    .load         (load),
    .len          (len_cl),
    .tx           (tx_data),
    .adv          (adv),
    .capture      (capture),
    .miso         (miso),
    .release_line (finish),
    .mosi         (mosi),
    .rx           (rx_sh)
  );

  always_comb begin
    setup_chk  = CNT_W'(c2t_q) + CNT_W'(1);
    setup_last = setup_chk + CNT_W'(hold_q);
    lead_last  = CNT_W'(half_lead) - CNT_W'(1);
    idle_last  = CNT_W'(half_idle) - CNT_W'(1);
    tail_last  = CNT_W'(t2c_q);
    last_bit   = (bit_q == len_q - LEN_W'(1));
  end

  // sequencing
  always_comb begin
    st_nx   = st;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    load    = 1'b0;
    adv     = 1'b0;
    capture = 1'b0;
    finish  = 1'b0;
    chain   = 1'b0;
    case (st)
      ST_IDLE: begin
        if (start) begin
          st_nx   = ST_SETUP;
          cnt_clr = 1'b1;
          load    = 1'b1;
        end
      end
      ST_SETUP: begin
        if (cnt == setup_chk && ena_n) begin
          st_nx = ST_SETUP;               // stall: clock stays idle
        end else if (cnt == setup_last) begin
          st_nx   = ST_LEAD;
          cnt_clr = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_LEAD: begin
        if (cnt == lead_last) begin
          st_nx   = ST_TRAIL;
          cnt_clr = 1'b1;
          capture = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_TRAIL: begin
        if (cnt == idle_last) begin
          cnt_clr = 1'b1;
          if (!last_bit) begin
            st_nx = ST_LEAD;
            adv   = 1'b1;
          end else if (hold_q && start) begin
            st_nx = ST_SETUP;
            chain = 1'b1;
            load  = 1'b1;
          end else begin
            st_nx = ST_TAIL;
          end
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_TAIL: begin
        if (cnt == tail_last) begin
          st_nx  = ST_IDLE;
          finish = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ps_q   <= '0;
      pol_q  <= 1'b0;
      hold_q <= 1'b0;
      c2t_q  <= '0;
      t2c_q  <= '0;
      len_q  <= LEN_W'(MIN_BITS);
      bit_q  <= '0;
    end else begin
      st <= st_nx;
      if (load) begin
        ps_q   <= ps_cfg;
        pol_q  <= pol_cfg;
        hold_q <= hold_cfg;
        c2t_q  <= c2t_cfg;
        t2c_q  <= t2c_cfg;
        len_q  <= len_cl;
        bit_q  <= '0;
      end else if (adv) begin
        bit_q <= bit_q + LEN_W'(1);
      end
    end
  end

  // registered pin outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      rx_data <= '0;
      done    <= 1'b0;
    end else begin
      cs_n <= (st_nx == ST_IDLE);
      done <= finish || chain;
      if (finish || chain) rx_data <= rx_sh;
      if (st == ST_IDLE || load) sclk <= pol_cfg;
      else                       sclk <= (st_nx == ST_LEAD) ? ~pol_q : pol_q;
    end
  end
endmodule

// File: rtl/spim_engine_chk.sv
module spim_engine_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic done
);
  // R5: no clock transition in the cycle after chip-select falls
  a_r5_quiet_after_cs: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |=> $stable(sclk));

  // R7: chip-select release always comes with done
  a_r7_release_has_done: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> done);

  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: done only closes an open frame
  a_r7_done_after_frame: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(!cs_n));

  // R4: inside a frame mosi moves only with an sclk edge or a word boundary
  a_r4_mosi_on_edge: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n) && !$stable(mosi)) |-> (!$stable(sclk) || done));
endmodule

bind spim_engine spim_engine_chk i_spim_engine_chk (
  .clk  (clk),
  .rst  (rst),
  .cs_n (cs_n),
  .sclk (sclk),
  .mosi (mosi),
  .done (done)
);

// File: tb/test_spim_engine.sv
module test_spim_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst, start, pol_cfg, hold_cfg, ena_n, miso;
  logic [15:0] tx_data, rx_data;
  logic [4:0]  len_cfg;
  logic [7:0]  ps_cfg, c2t_cfg, t2c_cfg;
  logic        cs_n, sclk, mosi, done;

  spim_engine i_spim_engine (
    .clk(clk), .rst(rst), .start(start), .tx_data(tx_data), .len_cfg(len_cfg),
    .ps_cfg(ps_cfg), .pol_cfg(pol_cfg), .c2t_cfg(c2t_cfg), .t2c_cfg(t2c_cfg),
    .hold_cfg(hold_cfg), .ena_n(ena_n), .miso(miso), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .rx_data(rx_data), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit start, ena_n, miso, pol, hold;
    bit [15:0] tx;
    bit [4:0] len;
    bit [7:0] ps, c2t, t2c;
    bit e_cs, e_sclk, e_mosi, e_done;
    bit [15:0] e_rx;
    int tag;
  } cyc_t;

  cyc_t q[$];
  int checks = 0, failures = 0, cur_tag = 1;
  bit finished = 0;
  bit last_pol = 0;
  bit [15:0] exp_rx = 0, pend_rx = 0;
  bit [15:0] p_tx = 0;
  bit [4:0] p_len = 0;
  bit [7:0] p_ps = 0, p_c2t = 0, p_t2c = 0;
  bit p_pol = 0, p_hold = 0;

  function automatic string tname(int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic mk(output cyc_t c);
    c.start = 0; c.ena_n = 0; c.miso = 0;
    c.tx = p_tx; c.len = p_len; c.ps = p_ps; c.c2t = p_c2t; c.t2c = p_t2c;
    c.pol = p_pol; c.hold = p_hold;
    c.e_cs = 1; c.e_sclk = 0; c.e_mosi = 0; c.e_done = 0; c.e_rx = exp_rx;
    c.tag = cur_tag;
  endtask

  task automatic put(cyc_t c);
    q.push_back(c);
    last_pol = c.pol;
  endtask

  task automatic idle(int n);
    cyc_t c;
    for (int i = 0; i < n; i++) begin
      mk(c); c.e_sclk = last_pol; put(c);
    end
  endtask

  // Appends the expected cycle-by-cycle picture of one word.
  task automatic xfer(bit [15:0] tx, bit [15:0] rxpat, bit [4:0] len, bit [7:0] ps,
                      bit pol, bit [7:0] c2t, bit [7:0] t2c, bit hold, int stall,
                      bit busy_start, bit chain_in, bit do_tail);
    cyc_t c;
    int n, per, hi, lo, h1, h2, dly, smp, ix;
    bit [15:0] mask;
    p_tx = tx; p_len = len; p_ps = ps; p_pol = pol; p_c2t = c2t; p_t2c = t2c; p_hold = hold;
    if (!chain_in) begin
      mk(c); c.start = 1; c.e_sclk = last_pol; put(c);
    end else begin
      ix = q.size() - 1;
      q[ix].start = 1; q[ix].tx = tx; q[ix].len = len; q[ix].ps = ps; q[ix].pol = pol;
      q[ix].c2t = c2t; q[ix].t2c = t2c; q[ix].hold = hold;
      last_pol = pol;
      exp_rx = pend_rx;
    end
    n   = (len < 2) ? 2 : (len > 16) ? 16 : int'(len);
    per = (ps == 0) ? 2 : int'(ps) + 1;
    hi  = per / 2;
    lo  = per - hi;
    h1  = pol ? lo : hi;
    h2  = pol ? hi : lo;
    smp = int'(c2t) + 1;
    dly = int'(c2t) + 2 + int'(hold);
    if (busy_start) begin
      p_tx = ~tx; p_len = 5'd3; p_ps = 8'd7; p_c2t = 0; p_t2c = 0; p_hold = 1; p_pol = !pol;
    end
    for (int i = 0; i < dly + stall; i++) begin
      mk(c); c.e_cs = 0; c.e_sclk = pol; c.e_mosi = tx[n-1];
      c.ena_n = (i >= smp && i < smp + stall);
      c.start = busy_start;
      if (i == 0 && chain_in) c.e_done = 1;
      put(c);
    end
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < h1; j++) begin
        mk(c); c.e_cs = 0; c.e_sclk = !pol; c.e_mosi = tx[n-1-k];
        c.miso = rxpat[n-1-k]; c.start = busy_start; put(c);
      end
      for (int j = 0; j < h2; j++) begin
        mk(c); c.e_cs = 0; c.e_sclk = pol; c.e_mosi = tx[n-1-k];
        c.miso = !rxpat[n-1-k]; c.start = busy_start; put(c);
      end
    end
    mask = (n == 16) ? 16'hFFFF : 16'((1 << n) - 1);
    pend_rx = rxpat & mask;
    if (do_tail) begin
      for (int t = 0; t <= int'(t2c); t++) begin
        mk(c); c.e_cs = 0; c.e_sclk = pol; c.e_mosi = tx[0]; c.start = busy_start; put(c);
      end
      exp_rx = pend_rx;
      mk(c); c.e_cs = 1; c.e_sclk = pol; c.e_mosi = 0; c.e_done = 1; put(c);
    end
  endtask

  initial begin
    rst = 1; start = 0; tx_data = 0; len_cfg = 0; ps_cfg = 0; pol_cfg = 0;
    c2t_cfg = 0; t2c_cfg = 0; hold_cfg = 0; ena_n = 0; miso = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(cs_n == 1, "R1", "cs_n", cs_n, 1);
    chk(sclk == 0, "R1", "sclk", sclk, 0);
    chk(mosi == 0, "R1", "mosi", mosi, 0);
    chk(done == 0, "R1", "done", done, 0);
    chk(rx_data == 0, "R1", "rx_data", rx_data, 0);

    cur_tag = 1; idle(3);
    cur_tag = 2;                     // R2: even, odd and minimum periods
    xfer(16'h00A5, 16'h003C, 5'd8, 8'd0, 0, 8'd0, 8'd0, 0, 0, 0, 0, 1); idle(2);
    xfer(16'h0034, 16'h00F1, 5'd8, 8'd4, 0, 8'd3, 8'd2, 0, 0, 0, 0, 1); idle(2);
    cur_tag = 3;                     // R3: polarity 1, odd period
    xfer(16'h0ABC, 16'h0F0F, 5'd12, 8'd2, 1, 8'd1, 8'd1, 0, 0, 0, 0, 1); idle(3);
    xfer(16'h0155, 16'h00AA, 5'd9, 8'd5, 1, 8'd0, 8'd4, 0, 0, 0, 0, 1); idle(2);
    cur_tag = 5;                     // R5: hold adds a setup cycle
    xfer(16'hC0DE, 16'hBEEF, 5'd16, 8'd1, 0, 8'd5, 8'd3, 1, 0, 0, 0, 1); idle(2);
    xfer(16'h0009, 16'h0006, 5'd4, 8'd3, 0, 8'd20, 8'd17, 0, 0, 0, 0, 1); idle(2);
    cur_tag = 6;                     // R6: slave-ready stall
    xfer(16'h005A, 16'h0093, 5'd8, 8'd1, 0, 8'd2, 8'd1, 0, 4, 0, 0, 1); idle(2);
    xfer(16'h01C3, 16'h0122, 5'd10, 8'd2, 1, 8'd3, 8'd0, 1, 3, 0, 0, 1); idle(2);
    cur_tag = 7;                     // R7: tail length and done
    xfer(16'h0006, 16'h0005, 5'd3, 8'd6, 0, 8'd1, 8'd9, 0, 0, 0, 0, 1); idle(2);
    cur_tag = 8;                     // R8: three chained words
    xfer(16'h00E7, 16'h0071, 5'd8, 8'd1, 0, 8'd1, 8'd2, 1, 0, 0, 0, 0);
    xfer(16'h0013, 16'h001C, 5'd5, 8'd4, 0, 8'd2, 8'd3, 1, 0, 0, 1, 0);
    xfer(16'h0ABD, 16'h0542, 5'd12, 8'd0, 0, 8'd0, 8'd1, 0, 0, 0, 1, 1); idle(3);
    cur_tag = 9;                     // R9: length clamp
    xfer(16'h0002, 16'h0001, 5'd1, 8'd1, 0, 8'd0, 8'd0, 0, 0, 0, 0, 1); idle(2);
    xfer(16'h9E37, 16'h6A1D, 5'd31, 8'd0, 1, 8'd1, 8'd0, 0, 0, 0, 0, 1); idle(2);
    cur_tag = 10;                    // R10: start and config ignored while busy
    xfer(16'h00C9, 16'h0036, 5'd8, 8'd2, 0, 8'd1, 8'd2, 0, 0, 1, 0, 1); idle(4);

    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      if (i == 0) rst = 0;
      start = q[i].start; ena_n = q[i].ena_n; miso = q[i].miso;
      tx_data = q[i].tx; len_cfg = q[i].len; ps_cfg = q[i].ps; pol_cfg = q[i].pol;
      c2t_cfg = q[i].c2t; t2c_cfg = q[i].t2c; hold_cfg = q[i].hold;
      chk(cs_n == q[i].e_cs, tname(q[i].tag), "cs_n", cs_n, q[i].e_cs);
      chk(sclk == q[i].e_sclk, tname(q[i].tag), "sclk", sclk, q[i].e_sclk);
      chk(mosi == q[i].e_mosi, "R4", "mosi", mosi, q[i].e_mosi);
      chk(done == q[i].e_done, "R7", "done", done, q[i].e_done);
      chk(rx_data == q[i].e_rx, "R3", "rx_data", rx_data, q[i].e_rx);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule